// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one load request from a group of 16 lanes and turns it into the smallest set of aligned memory transactions that covers it. Each lane supplies an active flag and a byte address. All lanes in the group share one word size. The block works in passes. Each pass anchors on the lowest-numbered lane that still needs service and picks the segment that holds that lane's address. It gathers every pending lane in that segment. Where the gathered lanes touch only one half of the segment, it narrows the transaction to that half, and it keeps narrowing down to a 32-byte floor.

Every transaction leaves on a valid/ready port. It carries an aligned base address, a size code and a mask of the lanes it serves. When the transaction is accepted, the block retires those lanes. When no lane is left, a one-cycle done pulse closes the group. The number of transactions therefore follows the address pattern: a unit-stride group needs one transaction, and a fully scattered group needs sixteen.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset, `grp_ready` is 1 and both `txn_valid` and `done` are 0.
- R2: A group is taken only on a cycle where `grp_valid` and `grp_ready` are both high. `grp_ready` is high only while no group is in progress. Group inputs that change while a group is in progress do not affect its transactions.
- R3: Each transaction's mask contains the lowest-numbered lane that was still pending when that transaction was formed, so transactions come out in the order of their lowest lanes.
- R4: The segment size follows `grp_wsize`: code 0 (2-byte words) gives 32 bytes, code 1 (4-byte) gives 64 bytes, and codes 2 (8-byte) and 3 (16-byte) give 128 bytes.
- R5: A transaction's mask is exactly the set of pending active lanes whose address lies in the anchor lane's segment, whatever their order within it.
- R6: When all gathered lanes of a 128-byte segment fall in one 64-byte half, the transaction is 64 bytes and is based at that half.
- R7: Narrowing repeats: when all gathered lanes of a 64-byte transaction fall in one 32-byte half, the transaction is 32 bytes and is based at that half.
- R8: `txn_size` encodes 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. `txn_addr` is always a multiple of that size.
- R9: A group whose active addresses span N distinct segments produces exactly N transactions, and then `done`. With `txn_ready` held high, `done` is seen 2N+2 cycles after the cycle in which the group is offered.
- R10: Inactive lanes never appear in a mask and never cause a transaction. A group with no active lane produces no transaction and only `done`, two cycles after it is offered.
- R11: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_addr`, `txn_size` and `txn_mask` hold their values into the next cycle.
- R12: `done` is high for exactly one cycle per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 1 | A group request is offered |
| grp_ready | output | 1 | Block is idle and takes a group |
| grp_active | input | LANES | Per-lane active flags |
| grp_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| grp_wsize | input | 2 | Word size code: 0=2 B, 1=4 B, 2=8 B, 3=16 B |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_addr | output | ADDR_W | Aligned base address of the transaction |
| txn_size | output | 2 | Size code: 0=32 B, 1=64 B, 2=128 B |
| txn_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse when the group is complete |

## Verification
The bench builds the block with its default values, LANES=16 and ADDR_W=32. Sixteen lanes make the worst case of sixteen separate transactions reachable. The 32-bit width leaves room for group bases well apart, so a stale lane address would land in a wrong segment and be caught. Directed groups cover each word size, each narrowing level, scattered and permuted lanes, inactive lanes, and an empty group. Randomized groups with a stalling `txn_ready` exercise the hold rule and the changing of group inputs while a group is in progress.

// File: rtl/hwc_pkg.sv
// Package: shared state type and size helpers for the coalescer.
// Assumes segment and transaction sizes are powers of two from 32 bytes up.
package hwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAN  = 2'd1,
        ST_ISSUE = 2'd2
    } hwc_state_e;

    // log2 of the smallest transaction (32 bytes)
    localparam int unsigned MIN_LOG = 5;

    // Segment size code for a word size code: 2B->32B, 4B->64B, 8B/16B->128B
    function automatic logic [1:0] seg_code_of(input logic [1:0] wsize);
        logic [1:0] c;
        case (wsize)
            2'd0:    c = 2'd0;
            2'd1:    c = 2'd1;
            default: c = 2'd2;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hwc_anchor.sv
// hwc_anchor: finds the lowest-numbered pending lane.
// Assumes LANES >= 2. found is low when no lane is pending.
module hwc_anchor #(
    parameter int LANES = 16,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // Priority pick: scan downward so the lowest set lane wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hwc_match.sv
// hwc_match: per-lane compare of each pending lane against the anchor segment.
// Assumes ADDR_W >= 7. Also exposes address bits 6 and 5 of every lane for narrowing.
module hwc_match
    import hwc_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        pend,
    input  logic [ADDR_W-1:0]       anchor_addr,
    input  logic [1:0]              seg_code,
    output logic [LANES-1:0]        hit,
    output logic [LANES-1:0]        half_hi,
    output logic [LANES-1:0]        quarter_hi
);

    logic [2:0] seg_shift;

    // Offset bits ignored when comparing segment numbers
    assign seg_shift = 3'(MIN_LOG) + {1'b0, seg_code};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        logic [ADDR_W-1:0] diff;

        assign lane_addr = addr_flat[g*ADDR_W +: ADDR_W];
        // Segment compare: equal once offset bits are shifted away
        assign diff          = lane_addr ^ anchor_addr;
        assign hit[g]        = pend[g] && ((diff >> seg_shift) == '0);
        assign half_hi[g]    = lane_addr[MIN_LOG+1];
        assign quarter_hi[g] = lane_addr[MIN_LOG];
    end

endmodule

// File: rtl/hwc_shrink.sv
// hwc_shrink: narrows a segment to the half, then the quarter, that the hit lanes use.
// Assumes the anchor lane is among the hit lanes, so its address picks the surviving half.
module hwc_shrink
    import hwc_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0]  hit,
    input  logic [LANES-1:0]  half_hi,
    input  logic [LANES-1:0]  quarter_hi,
    input  logic [1:0]        seg_code,
    input  logic [ADDR_W-1:0] anchor_addr,
    output logic [1:0]        size_code,
    output logic [ADDR_W-1:0] base_addr
);

    logic       one_half;
    logic       one_quarter;
    logic [2:0] size_shift;

    // One-side tests: hits all in the low half or all in the high half
    assign one_half    = ((hit & half_hi) == '0) || ((hit & ~half_hi) == '0);
    assign one_quarter = ((hit & quarter_hi) == '0) || ((hit & ~quarter_hi) == '0);

    // Stepwise narrowing from the segment size toward 32 bytes
    always_comb begin
        size_code = seg_code;
        if (size_code == 2'd2 && one_half) begin
            size_code = 2'd1;
        end
        if (size_code == 2'd1 && one_quarter) begin
            size_code = 2'd0;
        end
    end

    // Base: anchor address with offset bits of the final size cleared
    assign size_shift = 3'(MIN_LOG) + {1'b0, size_code};
    assign base_addr  = anchor_addr & ({ADDR_W{1'b1}} << size_shift);

endmodule

// File: rtl/hwc_coalescer.sv
// hwc_coalescer: turns one group of lane loads into aligned memory transactions.
// Assumes each lane address is aligned to the word size. Group inputs are sampled
// only on acceptance. Each pass takes one cycle to plan and at least one to issue.
module hwc_coalescer
    import hwc_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grp_valid,
    output logic                    grp_ready,
    input  logic [LANES-1:0]        grp_active,
    input  logic [LANES*ADDR_W-1:0] grp_addr,
    input  logic [1:0]              grp_wsize,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [1:0]              txn_size,
    output logic [LANES-1:0]        txn_mask,
    output logic                    done
);

    hwc_state_e              st;
    logic [LANES-1:0]        pend;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [1:0]              wsz_q;

    logic [IDX_W-1:0]        anc_idx;
    logic                    anc_found;
    logic [ADDR_W-1:0]       anc_addr;
    logic [1:0]              seg_c;
    logic [LANES-1:0]        hit;
    logic [LANES-1:0]        half_hi;
    logic [LANES-1:0]        quarter_hi;
    logic [1:0]              plan_size;
    logic [ADDR_W-1:0]       plan_base;

    // Group intake is open only while idle
    assign grp_ready = (st == ST_IDLE);

    // Anchor address and segment size of the current pass
    assign anc_addr = addr_q[anc_idx*ADDR_W +: ADDR_W];
    assign seg_c    = seg_code_of(wsz_q);

    hwc_anchor #(.LANES(LANES)) u_anchor (
        .pend  (pend),
        .idx   (anc_idx),
        .found (anc_found)
    );

    hwc_match #(.LANES(LANES), .ADDR_W(ADDR_W)) u_match (
        .addr_flat   (addr_q),
        .pend        (pend),
        .anchor_addr (anc_addr),
        .seg_code    (seg_c),
        .hit         (hit),
        .half_hi     (half_hi),
        .quarter_hi  (quarter_hi)
    );

    hwc_shrink #(.LANES(LANES), .ADDR_W(ADDR_W)) u_shrink (
        .hit         (hit),
        .half_hi     (half_hi),
        .quarter_hi  (quarter_hi),
        .seg_code    (seg_c),
        .anchor_addr (anc_addr),
        .size_code   (plan_size),
        .base_addr   (plan_base)
    );

    // Pass sequencer: accept, plan, hold until taken, retire lanes, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pend      <= '0;
            addr_q    <= '0;
            wsz_q     <= '0;
            txn_valid <= 1'b0;
            txn_addr  <= '0;
            txn_size  <= '0;
            txn_mask  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (grp_valid) begin
                        pend   <= grp_active;
                        addr_q <= grp_addr;
                        wsz_q  <= grp_wsize;
                        st     <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (anc_found) begin
                        txn_valid <= 1'b1;
                        txn_addr  <= plan_base;
                        txn_size  <= plan_size;
                        txn_mask  <= hit;
                        st        <= ST_ISSUE;
                    end else begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                ST_ISSUE: begin
                    if (txn_ready) begin
                        txn_valid <= 1'b0;
                        pend      <= pend & ~txn_mask;
                        st        <= ST_PLAN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hwc_checker.sv
// hwc_checker: protocol and structure properties of hwc_coalescer, observed at its ports.
// Keeps its own record of the lanes still owed, taken from the accepted group.
module hwc_checker #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grp_valid,
    input logic              grp_ready,
    input logic [LANES-1:0]  grp_active,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_addr,
    input logic [1:0]        txn_size,
    input logic [LANES-1:0]  txn_mask,
    input logic              done
);

    logic [LANES-1:0] owed;

    // Track lanes owed: loaded on acceptance, cleared as transactions are taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (grp_valid && grp_ready) begin
            owed <= grp_active;
        end else if (txn_valid && txn_ready) begin
            owed <= owed & ~txn_mask;
        end
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grp_ready |-> !txn_valid);

    p_mask_owed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask & ~owed) == '0));

    p_size_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_size != 2'd3));

    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_addr[4:0] == '0
                       && (txn_size == 2'd0 || !txn_addr[5])
                       && (txn_size != 2'd2 || !txn_addr[6])));

    p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (owed == '0));

    p_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0));

    p_hold_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> txn_valid);

    p_hold_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> $stable(txn_addr));

    p_hold_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> $stable(txn_size));

    p_hold_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> $stable(txn_mask));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind hwc_coalescer hwc_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_valid  (grp_valid),
    .grp_ready  (grp_ready),
    .grp_active (grp_active),
    .txn_valid  (txn_valid),
    .txn_ready  (txn_ready),
    .txn_addr   (txn_addr),
    .txn_size   (txn_size),
    .txn_mask   (txn_mask),
    .done       (done)
);

// File: tb/hwc_coalescer_tb.sv
`timescale 1ns/1ps
module hwc_coalescer_tb;

    localparam int LANES = 16;
    localparam int AW    = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               grp_valid = 1'b0;
    logic               grp_ready;
    logic [LANES-1:0]   grp_active = '0;
    logic [LANES*AW-1:0] grp_addr = '0;
    logic [1:0]         grp_wsize = '0;
    logic               txn_valid;
    logic               txn_ready = 1'b1;
    logic [AW-1:0]      txn_addr;
    logic [1:0]         txn_size;
    logic [LANES-1:0]   txn_mask;
    logic               done;

    int total = 0;
    int bad   = 0;
    int ready_mode = 0;
    bit mon_en = 1'b0;

    // Expected transactions of the current group, in issue order
    logic [AW-1:0]    ex_addr[$];
    logic [1:0]       ex_size[$];
    logic [LANES-1:0] ex_mask[$];

    // State for the hold check
    bit               held = 1'b0;
    logic [AW-1:0]    h_addr;
    logic [1:0]       h_size;
    logic [LANES-1:0] h_mask;

    always #2.5 clk = ~clk;

    hwc_coalescer #(.LANES(LANES), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_active(grp_active), .grp_addr(grp_addr), .grp_wsize(grp_wsize),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_size(txn_size), .txn_mask(txn_mask),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference: behavioural pass loop over the lane list, fills the queues
    function automatic int build_exp(input logic [LANES-1:0] act,
                                     input logic [AW-1:0] a [LANES], input int ws);
        logic [LANES-1:0] left;
        int n;
        int seg;
        left = act;
        n = 0;
        seg = (ws == 0) ? 32 : (ws == 1) ? 64 : 128;
        while (left != '0) begin
            int anc;
            int size;
            logic [AW-1:0] base;
            logic [LANES-1:0] m;
            anc = 0;
            while (!left[anc]) anc++;
            base = a[anc] - (a[anc] % seg);
            m = '0;
            for (int i = 0; i < LANES; i++)
                if (left[i] && a[i] >= base && a[i] < base + seg) m[i] = 1'b1;
            size = seg;
            while (size > 32) begin
                bit lo_only;
                bit hi_only;
                lo_only = 1'b1;
                hi_only = 1'b1;
                for (int i = 0; i < LANES; i++) begin
                    if (m[i]) begin
                        if (a[i] - base < size / 2) hi_only = 1'b0;
                        else                       lo_only = 1'b0;
                    end
                end
                if (lo_only) size = size / 2;
                else if (hi_only) begin base = base + size / 2; size = size / 2; end
                else break;
            end
            ex_addr.push_back(base);
            ex_size.push_back((size == 32) ? 2'd0 : (size == 64) ? 2'd1 : 2'd2);
            ex_mask.push_back(m);
            left = left & ~m;
            n++;
        end
        return n;
    endfunction

    // Per-cycle monitor: decide ready, then compare what the next edge transfers
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            txn_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (held) begin
                check(txn_valid === 1'b1, "R11", "valid dropped while stalled", txn_valid, 1);
                check(txn_addr === h_addr && txn_size === h_size && txn_mask === h_mask,
                      "R11", "fields changed while stalled", txn_addr, h_addr);
            end
            if (txn_valid && txn_ready) begin
                if (ex_addr.size() == 0) begin
                    check(1'b0, "R9", "unexpected transaction", txn_addr, 0);
                end else begin
                    logic [AW-1:0]    ea;
                    logic [1:0]       es;
                    logic [LANES-1:0] em;
                    ea = ex_addr.pop_front();
                    es = ex_size.pop_front();
                    em = ex_mask.pop_front();
                    check(txn_mask === em, "R3 R5 R10", "mask", txn_mask, em);
                    check(txn_size === es, "R4 R6 R7 R8", "size code", txn_size, es);
                    check(txn_addr === ea, "R6 R7 R8", "base address", txn_addr, ea);
                end
            end
            if (done) begin
                check(ex_addr.size() == 0, "R9", "transactions left at done", ex_addr.size(), 0);
            end
            held   = txn_valid && !txn_ready;
            h_addr = txn_addr;
            h_size = txn_size;
            h_mask = txn_mask;
        end
    end

    // Offer one group, disturb the inputs while it runs, wait for done
    task automatic run_group(input logic [LANES-1:0] act, input logic [AW-1:0] a [LANES],
                             input int ws, input int rmode, input string tag);
        int ntx;
        int n;
        ntx = build_exp(act, a, ws);
        ready_mode = rmode;
        @(negedge clk);
        check(grp_ready === 1'b1, "R2", {tag, " idle before offer"}, grp_ready, 1);
        grp_valid = 1'b1;
        grp_active = act;
        grp_wsize = 2'(ws);
        for (int i = 0; i < LANES; i++) grp_addr[i*AW +: AW] = a[i];
        n = 0;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (done) break;
            check(grp_ready === 1'b0, "R2", {tag, " ready while busy"}, grp_ready, 0);
            grp_active = ~act;
            grp_wsize  = 2'(ws) ^ 2'd1;
            grp_addr   = ~grp_addr;
        end
        grp_valid = 1'b0;
        check(done === 1'b1, "R9", {tag, " done seen"}, done, 1);
        if (rmode == 0)
            check(n == 2 * ntx + 2, "R9 R10", {tag, " cycles to done"}, n, 2 * ntx + 2);
        @(negedge clk);
        check(done === 1'b0, "R12", {tag, " done one cycle"}, done, 0);
        check(grp_ready === 1'b1 && txn_valid === 1'b0, "R2", {tag, " idle after"}, grp_ready, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] a [LANES];
        repeat (4) @(negedge clk);
        check(grp_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0,
              "R1", "reset outputs", {grp_ready, txn_valid, done}, 3'b100);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R10: empty group gives done only
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_9000 + i * 4;
        run_group('0, a, 1, 0, "R10 empty");

        // R4 R5: 4-byte unit stride fills a 64-byte segment
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_1000 + i * 4;
        run_group('1, a, 1, 0, "R4 stride4");

        // R7: 4-byte words inside the low 32 bytes, permuted
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_2000 + ((7 - (i % 8)) * 4);
        run_group('1, a, 1, 0, "R7 quarter");

        // R4: 8-byte unit stride fills 128 bytes
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_3000 + i * 8;
        run_group('1, a, 2, 0, "R4 stride8");

        // R6: 8-byte words in the upper 64-byte half
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_3040 + (i % 8) * 8;
        run_group('1, a, 2, 0, "R6 half");

        // R7: 16-byte words narrowed twice to the top 32 bytes
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_4060 + (i % 2) * 16;
        run_group('1, a, 3, 0, "R7 two-step");

        // R9: 2-byte words, one segment per lane, 16 transactions
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_5000 + (LANES - 1 - i) * 32;
        run_group('1, a, 0, 0, "R9 scatter");

        // R11: the same scatter with a stalling consumer
        run_group('1, a, 0, 1, "R11 stall");

        // R3 R10: lane 0 inactive with a far address, alternating segments
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_6000 + (i % 2) * 256 + i * 4;
        a[0] = 32'h0000_F000;
        run_group(16'hFFFE, a, 1, 0, "R3 anchor");

        // Randomized groups, mixed sizes and consumers
        for (int g = 0; g < 40; g++) begin
            int ws;
            int wb;
            logic [LANES-1:0] act;
            ws = int'($urandom % 4);
            wb = 2 << ws;
            act = 16'($urandom);
            for (int i = 0; i < LANES; i++)
                a[i] = (32'h0001_0000 + g * 32'h1000 + ($urandom % 512)) & ~(32'(wb) - 1);
            run_group(act, a, ws, g % 2, "R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule